// File: doc/BRIEF.md
# System Clock Divider Bank

This block sits downstream of a clock multiplier and turns its high-frequency reference clock into six derived clock waveforms, all generated as registered-state signals in the reference domain. Four channels divide by fixed ratios chosen at build time. The other two channels take their ratios from software through a small register write/read port. Software also writes a multiplier field into the port. Hardware uses that field only to judge whether the programmed combination is in range. There is no pin that selects the multiplier, so software must write it after every reset.

Each channel counts reference cycles through a period of N cycles. The output is high during the first floor(N/2) cycles of the period and low for the remainder. A ratio that software writes is held in a pending register. It moves into the running channel only when the current period ends, so the output never has a shortened pulse. Channel 4 always divides by an even ratio. A further tap divides channel 4 by two to drive an external memory interface clock. A combinational flag reports when the programmed multiplier and channel 4 ratio would place the multiplier output or the channel 4 frequency outside their limits.

Top module: `sysclk_divbank`

## Requirements
- R1: While reset is asserted and directly after it, div_clk reads 6'b111111, mem_clk reads 0, and the fields read back as 0 for the multiplier, 2 for channel 2 (divide-by-3) and 3 for channel 4 (divide-by-8).
- R2: The fixed channels are div_clk[0], div_clk[2], div_clk[4] and div_clk[5]. They divide by the parameters DIV1, DIV3, DIV5 and DIV6, which default to 3, 6, 2 and 4.
- R3: Channel 2 (div_clk[1]) divides by field+1, using the 5-bit field at address 1. A field of 0 holds the output high.
- R4: Channel 4 (div_clk[3]) divides by 2*(field+1), using the 4-bit field at address 2. For example, a field of 3 gives divide-by-8.
- R5: A ratio write only updates the pending field. The running ratio of a channel changes only at the last cycle of its current period. Of several writes made within one period, only the last one takes effect.
- R6: mem_clk toggles at the end of every channel 4 period, which makes it channel 4 divided by two.
- R7: The register map is as follows. Address 0 holds the multiplier field in bits [4:0], encoded as multiply-by-(field+1). Address 1 holds the channel 2 field in bits [4:0]. Address 2 holds the channel 4 field in bits [3:0]. Address 3 reads as 0 and ignores writes. Unused bits read as 0. A write takes effect at the clock edge where reg_wr is high, and reg_rdata is combinational from reg_addr.
- R8: cfg_bad is 1 when any of the following holds: REF_IN_MHZ*(mult+1) is below PLL_MIN_MHZ; that product is above PLL_MAX_MHZ; the product divided by the channel 4 ratio is above CH4_MAX_MHZ or below CH4_MIN_MHZ. The defaults are 35, 300, 1000, 100 and 20.
- R9: In every period of N>1 cycles, the output is high for the first floor(N/2) cycles and low for the remaining cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-frequency reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| div_clk | output | 6 | Derived clocks, channel 1 in bit 0 |
| mem_clk | output | 1 | Channel 4 divided by two |
| cfg_bad | output | 1 | Out-of-range configuration flag |

## Verification
All six div_clk bits and mem_clk take a new value after every reference edge. Their expected values are formed at each rising edge from the pending and running ratios that the requirements define. These values go into a queue. They are popped and compared at the next falling edge, which is the first point where the registered outputs have settled. A write changes reg_rdata and cfg_bad from the first falling edge after its capturing edge, and the checks of those two outputs are made there. A ratio written in the middle of a period is expected in the period after the current one. The queued model therefore keeps the pending value apart from the running value, and it applies the pending value only on the wrap edge.

// File: rtl/sysclk_divbank.sv
module sysclk_divbank #(
  parameter int CW          = 6,
  parameter int DIV1        = 3,
  parameter int DIV3        = 6,
  parameter int DIV5        = 2,
  parameter int DIV6        = 4,
  parameter int REF_IN_MHZ  = 35,
  parameter int PLL_MIN_MHZ = 300,
  parameter int PLL_MAX_MHZ = 1000,
  parameter int CH4_MIN_MHZ = 20,
  parameter int CH4_MAX_MHZ = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic [5:0] div_clk,
  output logic       mem_clk,
  output logic       cfg_bad
);
  localparam int NCH = 6;

  logic [4:0] mult_f, r2_f;
  logic [3:0] r4_f;
  logic [CW-1:0] tgt [NCH];
  logic [CW-1:0] cnt [NCH];
  logic [CW-1:0] cur [NCH];
  logic [NCH-1:0] wrap;

  function automatic logic [CW-1:0] rst_ratio(input int i);
    case (i)
      0: rst_ratio = CW'(DIV1);
      1: rst_ratio = CW'(3);
      2: rst_ratio = CW'(DIV3);
      3: rst_ratio = CW'(8);
      4: rst_ratio = CW'(DIV5);
      default: rst_ratio = CW'(DIV6);
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mult_f <= 5'd0;
      r2_f   <= 5'd2;
      r4_f   <= 4'd3;
    end else if (reg_wr) begin
      case (reg_addr)
        2'd0: mult_f <= reg_wdata[4:0];
        2'd1: r2_f   <= reg_wdata[4:0];
        2'd2: r4_f   <= reg_wdata[3:0];
        default: ;
      endcase
    end

  always_comb
    case (reg_addr)
      2'd0: reg_rdata = {3'b000, mult_f};
      2'd1: reg_rdata = {3'b000, r2_f};
      2'd2: reg_rdata = {4'b0000, r4_f};
      default: reg_rdata = 8'h00;
    endcase

  assign tgt[0] = CW'(DIV1);
  assign tgt[1] = CW'(r2_f) + CW'(1);
  assign tgt[2] = CW'(DIV3);
  assign tgt[3] = (CW'(r4_f) + CW'(1)) << 1;
  assign tgt[4] = CW'(DIV5);
  assign tgt[5] = CW'(DIV6);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign wrap[i] = (cnt[i] == cur[i] - CW'(1));
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cnt[i] <= '0;
        cur[i] <= rst_ratio(i);
      end else if (wrap[i]) begin
        cnt[i] <= '0;
        cur[i] <= tgt[i];
      end else begin
        cnt[i] <= cnt[i] + CW'(1);
      end
    assign div_clk[i] = (cur[i] == CW'(1)) ? 1'b1 : (cnt[i] < (cur[i] >> 1));
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       mem_clk <= 1'b0;
    else if (wrap[3]) mem_clk <= ~mem_clk;

  int pll_mhz, d4;
  always_comb begin
    pll_mhz = REF_IN_MHZ * (int'(mult_f) + 1);
    d4      = 2 * (int'(r4_f) + 1);
    cfg_bad = (pll_mhz < PLL_MIN_MHZ) || (pll_mhz > PLL_MAX_MHZ) ||
              (pll_mhz > CH4_MAX_MHZ * d4) || (pll_mhz < CH4_MIN_MHZ * d4);
  end

  AST_CH2_HOLD_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt[1] != '0) |-> (cur[1] == $past(cur[1]))); // R5
  AST_CH4_HOLD_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt[3] != '0) |-> (cur[3] == $past(cur[3]))); // R5
  AST_CH4_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    cur[3][0] == 1'b0); // R4
  AST_MEMCLK_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_clk != $past(mem_clk)) |-> (cnt[3] == '0)); // R6
  AST_CH1_RISE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(div_clk[0]) |-> (cnt[0] == '0)); // R9
  AST_CH2_FIELD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd1) |=> (r2_f == $past(reg_wdata[4:0]))); // R7
endmodule

// File: tb/tb_sysclk_divbank.sv
module tb_sysclk_divbank;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [5:0] div_clk;
  logic       mem_clk;
  logic       cfg_bad;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sysclk_divbank dut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .div_clk(div_clk),
    .mem_clk(mem_clk), .cfg_bad(cfg_bad));

  int m_mult, m_r2, m_r4;
  int m_cnt [6];
  int m_cur [6];
  bit m_mem;
  logic [6:0] sb_q [$];

  function automatic int fixed_or_prog(input int i);
    case (i)
      0: return 3;
      1: return m_r2 + 1;
      2: return 6;
      3: return 2 * (m_r4 + 1);
      4: return 2;
      default: return 4;
    endcase
  endfunction

  task automatic model_reset();
    m_mult = 0; m_r2 = 2; m_r4 = 3; m_mem = 1'b0;
    for (int i = 0; i < 6; i++) begin m_cnt[i] = 0; m_cur[i] = fixed_or_prog(i); end
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      logic [6:0] e;
      for (int i = 0; i < 6; i++) begin
        if (m_cnt[i] == m_cur[i] - 1) begin
          if (i == 3) m_mem = ~m_mem;
          m_cnt[i] = 0;
          m_cur[i] = fixed_or_prog(i);
        end else m_cnt[i]++;
      end
      if (reg_wr) case (reg_addr)
        2'd0: m_mult = int'(reg_wdata[4:0]);
        2'd1: m_r2   = int'(reg_wdata[4:0]);
        2'd2: m_r4   = int'(reg_wdata[3:0]);
        default: ;
      endcase
      for (int i = 0; i < 6; i++)
        e[i] = (m_cur[i] == 1) ? 1'b1 : (m_cnt[i] < m_cur[i] / 2);
      e[6] = m_mem;
      sb_q.push_back(e);
    end
  end

  function automatic string ch_tag(input int i);
    case (i)
      1: return "R3/R5/R9";
      3: return "R4/R5/R9";
      6: return "R6";
      default: return "R2/R9";
    endcase
  endfunction

  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      logic [6:0] e, a;
      e = sb_q.pop_front();
      a = {mem_clk, div_clk};
      for (int i = 0; i < 7; i++) begin
        checks++;
        if (a[i] !== e[i]) begin
          errors++;
          $display("FAIL %s output bit %0d at %0t: actual %b expected %b", ch_tag(i), i, $time, a[i], e[i]);
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input string tag, input int exp);
    @(negedge clk);
    reg_addr = a;
    #1 chk(tag, int'(reg_rdata), exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    model_reset();
    repeat (4) @(negedge clk);
    chk("R1 div_clk in reset", int'(div_clk), 63);
    chk("R1 mem_clk in reset", int'(mem_clk), 0);
    rst_n = 1'b1;
    rd(2'd0, "R1 mult reset field", 0);
    rd(2'd1, "R1 ch2 reset field", 2);
    rd(2'd2, "R1 ch4 reset field", 3);
    chk("R8 unprogrammed multiplier flagged", int'(cfg_bad), 1);
    idle(60);
    wr(2'd0, 8'hF3);
    rd(2'd0, "R7 mult readback upper bits dropped", 19);
    chk("R8 700MHz with div8 in range", int'(cfg_bad), 0);
    wr(2'd1, 8'd6);
    rd(2'd1, "R7 ch2 readback", 6);
    idle(90);
    wr(2'd2, 8'h30);
    rd(2'd2, "R7 ch4 readback", 0);
    chk("R8 ch4 at 350MHz flagged", int'(cfg_bad), 1);
    idle(40);
    wr(2'd2, 8'd15);
    chk("R8 ch4 at 21.9MHz in range", int'(cfg_bad), 0);
    idle(200);
    wr(2'd1, 8'd0);
    idle(40);
    wr(2'd1, 8'd31);
    wr(2'd1, 8'd4);
    wr(2'd1, 8'd9);
    idle(120);
    wr(2'd3, 8'hFF);
    rd(2'd3, "R7 address 3 reads zero", 0);
    rd(2'd1, "R7 address 3 write ignored", 9);
    rd(2'd2, "R7 ch4 unchanged", 15);
    wr(2'd0, 8'd31);
    chk("R8 1120MHz above limit", int'(cfg_bad), 1);
    wr(2'd2, 8'd7);
    idle(150);
    wr(2'd2, 8'd1);
    idle(60);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin @(posedge clk); cyc++; end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired: actual %0d cycles expected completion", cyc);
    end
    @(negedge clk);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule